// File: doc/BRIEF.md
# Per-Channel Silence Detector

This block watches six incoming audio channels and reports, for each one, when the channel has received nothing but exact-zero samples for a long stretch. Each channel has its own sample bus and a one-cycle valid strobe. A per-channel run counter advances only on that channel's strobes. Its flag becomes active once the run of consecutive zero samples reaches 1024. A single nonzero sample ends the run at once.

A combined flag is active only while every channel's flag is active. One polarity input sets whether all seven outputs are active-high or active-low. The block sits on the received data, ahead of any channel copying or gain stage. Each flag therefore describes only what actually arrived on its own channel's input.

Top module: `zero_watch`

## Requirements
- R1: A channel flag becomes active on the clock edge that accepts the 1024th consecutive zero sample on that channel. After 1023 consecutive zero samples it is still inactive.
- R2: A valid sample with any nonzero bit (including only the least significant bit, or only the sign bit) resets that channel's run. The flag is inactive from the clock edge that accepts that sample.
- R3: The run count saturates at 1024. The flag stays active for any number of further zero samples.
- R4: A channel's run changes only on clock edges where that channel's valid bit is 1. Cycles without its strobe leave that channel's flag unchanged, even while other channels are strobed.
- R5: The combined flag is active exactly when all six channel flags are active.
- R6: With `pol_low` = 0 an active flag reads 1 and an inactive flag reads 0. With `pol_low` = 1 the levels are inverted. A change of `pol_low` shows up on the outputs without waiting for a clock edge and without altering any run count.
- R7: While `rst_n` is 0, every run count is zero and all seven outputs are at the inactive level for the current `pol_low`.
- R8: Each channel's flag depends only on that channel's own sample bus and strobe. Channel k occupies bits [24k+23:24k] of `smp_data` and bit k of `smp_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data | input | 144 | Six 24-bit samples, channel k in bits [24k+23:24k] |
| smp_vld | input | 6 | Per-channel sample strobe, bit k for channel k |
| pol_low | input | 1 | Output polarity: 0 active-high, 1 active-low |
| ch_flag | output | 6 | Per-channel silence flags at the selected polarity |
| all_flag | output | 1 | Combined flag, all channels silent, at the selected polarity |

## Verification
The bench builds the block with its default values: six channels, 24-bit samples and a run length of 1024. The full-length run can therefore be driven in a few thousand cycles. Those values expose the exact 1023/1024 threshold, saturation beyond it, and the single-LSB and sign-bit-only clearing samples. They also make it possible to interleave strobes on one channel with silence on the others, and to invert polarity while channels are in mixed states.

// File: rtl/zw_pkg.sv
package zw_pkg;

    // Output polarity encoding driven by the pol_low input
    typedef enum logic {
        ZW_ACT_HIGH = 1'b0,
        ZW_ACT_LOW  = 1'b1
    } zw_pol_e;

    // Convert an internal active bit to the pin level for a polarity
    function automatic logic zw_drive(input logic active, input zw_pol_e pol);
        return (pol == ZW_ACT_LOW) ? ~active : active;
    endfunction

endpackage

// File: rtl/zw_run_counter.sv
module zw_run_counter #(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic [SAMPLE_W-1:0] data_i,
    output logic                silent_o
);

    localparam int               CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             hit;
    } run_state_t;

    run_state_t st_d, st_q;
    logic       is_zero;

    assign is_zero = (data_i == '0);

    always_comb begin
        st_d = st_q;
        if (vld_i) begin
            if (!is_zero) begin
                st_d.run = '0;
            end else if (st_q.run != LIMIT) begin
                st_d.run = st_q.run + 1'b1;
            end
        end
        st_d.hit = (st_d.run == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign silent_o = st_q.hit;

endmodule

// File: rtl/zw_flag_driver.sv
module zw_flag_driver
    import zw_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] silent_i,
    input  logic              pol_low_i,
    output logic [NUM_CH-1:0] ch_flag_o,
    output logic              all_flag_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] ch;
        logic              all;
    } flag_out_t;

    flag_out_t out_d;
    zw_pol_e   pol;

    assign pol = zw_pol_e'(pol_low_i);

    always_comb begin
        out_d.all = zw_drive(&silent_i, pol);
        for (int k = 0; k < NUM_CH; k++) begin
            out_d.ch[k] = zw_drive(silent_i[k], pol);
        end
    end

    assign ch_flag_o  = out_d.ch;
    assign all_flag_o = out_d.all;

endmodule

// File: rtl/zero_watch.sv
module zero_watch #(
    parameter int NUM_CH   = 6,
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic [NUM_CH-1:0]          smp_vld,
    input  logic                       pol_low,
    output logic [NUM_CH-1:0]          ch_flag,
    output logic                       all_flag
);

    logic [NUM_CH-1:0] silent;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        zw_run_counter #(
            .SAMPLE_W (SAMPLE_W),
            .RUN_LEN  (RUN_LEN)
        ) u_run (
            .clk      (clk),
            .rst_n    (rst_n),
            .vld_i    (smp_vld[g]),
            .data_i   (smp_data[g*SAMPLE_W +: SAMPLE_W]),
            .silent_o (silent[g])
        );
    end

    zw_flag_driver #(
        .NUM_CH (NUM_CH)
    ) u_drv (
        .silent_i   (silent),
        .pol_low_i  (pol_low),
        .ch_flag_o  (ch_flag),
        .all_flag_o (all_flag)
    );

endmodule

// File: rtl/zw_chk.sv
module zw_chk #(
    parameter int NUM_CH   = 6,
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input logic [NUM_CH-1:0]          smp_vld,
    input logic                       pol_low,
    input logic [NUM_CH-1:0]          ch_flag,
    input logic                       all_flag
);

    localparam int SH_W = $clog2(RUN_LEN + 1) + 1;

    logic [NUM_CH-1:0] act;
    logic              all_act;

    assign act     = ch_flag ^ {NUM_CH{pol_low}};
    assign all_act = all_flag ^ pol_low;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_c
        logic [SH_W-1:0] shadow_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (smp_vld[g]) begin
                if (smp_data[g*SAMPLE_W +: SAMPLE_W] != '0) begin
                    shadow_q <= '0;
                end else if (shadow_q < SH_W'(RUN_LEN)) begin
                    shadow_q <= shadow_q + 1'b1;
                end
            end
        end

        // R1
        run_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            act[g] == (shadow_q >= SH_W'(RUN_LEN)));

        // R2
        nonzero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld[g] && smp_data[g*SAMPLE_W +: SAMPLE_W] != '0) |=> !act[g]);

        // R4
        no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !smp_vld[g] |=> act[g] == $past(act[g]));
    end

    // R5
    all_implies_each_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_act |-> (&act));

    // R5
    each_implies_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&act) |-> all_act);

    // R7
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (act == '0 && !all_act);
        end
    end

endmodule

bind zero_watch zw_chk #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .RUN_LEN  (RUN_LEN)
) u_zw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_data (smp_data),
    .smp_vld  (smp_vld),
    .pol_low  (pol_low),
    .ch_flag  (ch_flag),
    .all_flag (all_flag)
);

// File: tb/zero_watch_tb_top.sv
module zero_watch_tb_top;

    localparam int NUM_CH   = 6;
    localparam int SAMPLE_W = 24;
    localparam int RUN_LEN  = 1024;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [NUM_CH*SAMPLE_W-1:0] smp_data = '0;
    logic [NUM_CH-1:0]          smp_vld = '0;
    logic                       pol_low = 1'b0;
    logic [NUM_CH-1:0]          ch_flag;
    logic                       all_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int          model_run [NUM_CH];
    logic [NUM_CH:0] exp_q [$];
    string           req_q [$];

    always #5 clk = ~clk;

    zero_watch #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W),
        .RUN_LEN  (RUN_LEN)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_data (smp_data),
        .smp_vld  (smp_vld),
        .pol_low  (pol_low),
        .ch_flag  (ch_flag),
        .all_flag (all_flag)
    );

    task automatic check(input bit ok, input string req, input logic [NUM_CH:0] act,
                         input logic [NUM_CH:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected outputs
    task automatic step(input logic [NUM_CH-1:0] vld, input logic [NUM_CH-1:0] nz,
                        input logic [SAMPLE_W-1:0] val, input logic pol, input string req);
        logic [NUM_CH-1:0] act_bits;
        @(negedge clk);
        smp_vld = vld;
        pol_low = pol;
        for (int k = 0; k < NUM_CH; k++) begin
            smp_data[k*SAMPLE_W +: SAMPLE_W] = nz[k] ? val : '0;
            if (vld[k]) begin
                if (nz[k] && val != '0) model_run[k] = 0;
                else if (model_run[k] < RUN_LEN) model_run[k]++;
            end
            act_bits[k] = (model_run[k] >= RUN_LEN);
        end
        exp_q.push_back({(&act_bits) ^ pol, act_bits ^ {NUM_CH{pol}}});
        req_q.push_back(req);
    endtask

    // Monitor: pops one expected item per clock edge once items are queued
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [NUM_CH:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check({all_flag, ch_flag} === e, r, {all_flag, ch_flag}, e);
        end
    end

    localparam logic [NUM_CH-1:0] ALL = '1;
    localparam logic [NUM_CH-1:0] NONE = '0;

    initial begin
        for (int k = 0; k < NUM_CH; k++) model_run[k] = 0;
        // R7: reset state at both polarities
        pol_low = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check({all_flag, ch_flag} === 7'h7f, "R7", {all_flag, ch_flag}, 7'h7f);
        pol_low = 1'b0;
        #1;
        check({all_flag, ch_flag} === 7'h00, "R7 R6", {all_flag, ch_flag}, 7'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: 1023 zero samples leave flags inactive, the 1024th sets them
        for (int n = 0; n < RUN_LEN - 1; n++) step(ALL, NONE, '0, 1'b0, "R1");
        step(ALL, NONE, '0, 1'b0, "R1 R5");
        // R3: saturated run keeps flags active
        for (int n = 0; n < 40; n++) step(ALL, NONE, '0, 1'b0, "R3");
        // R2 / R8: LSB-only sample on channel 2 clears only that channel
        step(ALL, 6'b000100, 24'h000001, 1'b0, "R2 R8");
        step(NONE, NONE, '0, 1'b0, "R5");
        // R6: polarity inversion with mixed states
        step(NONE, NONE, '0, 1'b1, "R6");
        step(NONE, NONE, '0, 1'b1, "R6");
        // R2: sign-bit-only sample on channel 0
        step(6'b000001, 6'b000001, 24'h800000, 1'b1, "R2");
        // R4: only channel 2 strobed, with idle gaps
        for (int n = 0; n < RUN_LEN; n++) begin
            step(6'b000100, NONE, '0, 1'b1, "R4");
            step(NONE, NONE, '0, 1'b1, "R4");
        end
        // R5: channel 0 brought back, combined flag returns
        for (int n = 0; n < RUN_LEN; n++) step(6'b000001, NONE, '0, 1'b0, "R5 R8");
        step(NONE, NONE, '0, 1'b0, "R5");
        // R8: nonzero on channel 5 only
        step(ALL, 6'b100000, 24'h00f00d, 1'b0, "R8");
        step(NONE, NONE, '0, 1'b0, "R8");

        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule